// File: doc/BRIEF.md
# SPI Controller Register and Interrupt Front End

This block is the register side of an SPI master/slave controller. A bus master reaches ten 32-bit registers through aligned word accesses. The block turns those accesses into push and pop strobes for the transmit and receive FIFOs. It keeps the control, configuration, interrupt-enable, DMA, period and test words. It builds a status word from the FIFO levels and from two sticky events reported by the burst engine, and it drives a level interrupt and one active-low chip select per channel. The serial shifter, the FIFOs and any DMA logic sit outside the block.

Bit 0 of the control word is the enable. While it is clear, only the control register can be written. Any write to control that leaves the enable clear acts as a soft reset. A soft reset wipes every other register, flushes both FIFOs, forces the status word to its idle value and raises every chip select, but it keeps the value just written to control. A hardware reset does the same and also clears control.

Word map (byte offset): 0x00 receive data, 0x04 transmit data, 0x08 control, 0x0C configuration, 0x10 interrupt enable, 0x14 DMA, 0x18 status, 0x1C period, 0x20 test, 0x24 message. Status bits: 0 transmit empty, 1 transmit has space (not full), 2 transmit full, 3 receive ready (not empty), 4 receive full, 5 receive overflow (sticky), 6 transfer complete (sticky). Interrupt-enable bits use the same positions.

Top module: `spi_fe_top`

## Requirements
- R1: The word index is the byte address divided by 4. An access with address bits [1:0] non-zero, or with an index of 10 or more, reads as 0 and its write changes nothing.
- R2: While control bit 0 is 0, a write to any register other than control (offset 0x08) is ignored: no register changes and no transmit push occurs.
- R3: A write to control with bit 0 equal to 0 is a soft reset. `fifo_flush` is high during that access. From the next cycle, configuration, interrupt enable, DMA, period and test read 0, status reads 0x03 while the FIFOs report empty, `irq` is 0, all `cs_n` bits are 1, and control holds the written value.
- R4: After hardware reset, control and all other registers are 0, status is 0x03 with empty FIFOs, `irq` is 0 and all `cs_n` bits are 1.
- R5: Status bits 0 to 4 mirror `tx_empty`, not `tx_full`, `tx_full`, not `rx_empty` and `rx_full`. They change on the clock edge after the FIFO signal changes.
- R6: Status bits 5 and 6 are set by a one-cycle pulse on `rx_overrun` and on `xfer_done`. Writing 1 to either bit at offset 0x18 clears it. Writing the other status bits has no effect. An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R7: `irq` equals the OR of (status AND interrupt enable) and is registered, so it changes on the same edge as the status bits.
- R8: When enabled, a write to offset 0x04 raises `tx_push` with `tx_data` equal to the written word, unless `tx_full` is 1, in which case the write is dropped.
- R9: When enabled, a read of offset 0x00 pops the receive FIFO and returns its head word. If `rx_empty` is 1 it returns 0xDEADBEEF and does not pop. Reads of offsets 0x04 and 0x24 return 0. Read data appears with `acc_rvalid` one cycle after the access.
- R10: Writes to offsets 0x00 and 0x24 are ignored: they cause no push and no pop, and the message offset still reads 0.
- R11: A control write with bit 0 equal to 1 makes channel s the active channel, where s = control[13:12]. If master bit control[4+s] is 1, `cs_n[s]` goes to 0 and every other `cs_n` bit goes to 1 on the next edge. If that master bit is 0, `cs_n` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Byte address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read data valid, one cycle after a read access |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_data | output | 32 | Word pushed to the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_data | input | 32 | Head word of the receive FIFO (show-ahead) |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| fifo_flush | output | 1 | Flush both FIFOs (soft reset) |
| xfer_done | input | 1 | Burst engine: transfer complete pulse |
| rx_overrun | input | 1 | Burst engine: receive overflow pulse |
| irq | output | 1 | Level interrupt |
| cs_n | output | NUM_CS | Active-low chip selects |
| ctrl_o | output | 32 | Control word for the burst engine |
| config_o | output | 32 | Configuration word for the burst engine |
| dma_o | output | 32 | DMA word |
| period_o | output | 32 | Period word for the burst engine |

## Verification
A write-one-to-clear of a sticky status bit and the engine event that sets that bit can land in the same cycle. The bench provokes this by pulsing `rx_overrun` during the status write that clears bit 5, then reads the status back and expects the bit to stay set; a plain clear that follows must then remove it. The bench also walks the FIFO flags through several patterns and checks that the interrupt rises exactly one edge after the flag change, never in the same cycle.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  localparam int DW   = 32;
  localparam int NREG = 10;

  // word indices (byte offset / 4); software depends on these positions
  localparam logic [3:0] IX_RXD  = 4'd0;
  localparam logic [3:0] IX_TXD  = 4'd1;
  localparam logic [3:0] IX_CTRL = 4'd2;
  localparam logic [3:0] IX_CFG  = 4'd3;
  localparam logic [3:0] IX_IEN  = 4'd4;
  localparam logic [3:0] IX_DMA  = 4'd5;
  localparam logic [3:0] IX_STAT = 4'd6;
  localparam logic [3:0] IX_PER  = 4'd7;
  localparam logic [3:0] IX_TST  = 4'd8;
  localparam logic [3:0] IX_MSG  = 4'd9;
  localparam logic [3:0] IX_NONE = 4'hF;

  localparam int CTRL_EN = 0;

  // status layout
  localparam int SB_TXE = 0;
  localparam int SB_TXS = 1;
  localparam int SB_TXF = 2;
  localparam int SB_RXR = 3;
  localparam int SB_RXF = 4;
  localparam int SB_RO  = 5;
  localparam int SB_TC  = 6;
  localparam int STAT_W = 7;

  localparam logic [STAT_W-1:0] STAT_IDLE = 7'h03;
  localparam logic [STAT_W-1:0] W1C_MASK  = 7'h60;

  // plain storage words and the index each one answers to
  localparam int PLAIN_N = 4;

  function automatic logic [3:0] plain_slot(input int s);
    case (s)
      0:       return IX_CFG;
      1:       return IX_DMA;
      2:       return IX_PER;
      default: return IX_TST;
    endcase
  endfunction

  // level-derived status bits; sticky bits are zero here
  function automatic logic [STAT_W-1:0] level_flags(input logic txe, input logic txf,
                                                    input logic rxe, input logic rxf);
    logic [STAT_W-1:0] f;
    f         = '0;
    f[SB_TXE] = txe;
    f[SB_TXS] = ~txf;
    f[SB_TXF] = txf;
    f[SB_RXR] = ~rxe;
    f[SB_RXF] = rxf;
    return f;
  endfunction

  // sticky bits: clear by write-one, then events set (event wins)
  function automatic logic [STAT_W-1:0] sticky_next(input logic [STAT_W-1:0] cur,
                                                    input logic clr_we,
                                                    input logic [STAT_W-1:0] clr_val,
                                                    input logic ev_ro, input logic ev_tc);
    logic [STAT_W-1:0] keep;
    logic [STAT_W-1:0] evs;
    keep = cur & W1C_MASK;
    if (clr_we) keep = keep & ~(clr_val & W1C_MASK);
    evs        = '0;
    evs[SB_RO] = ev_ro;
    evs[SB_TC] = ev_tc;
    return keep | evs;
  endfunction

  function automatic logic irq_level(input logic [STAT_W-1:0] st,
                                     input logic [STAT_W-1:0] en);
    return |(st & en);
  endfunction

endpackage

// File: rtl/spi_fe_decode.sv
module spi_fe_decode
  import spi_fe_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [3:0]    idx
);

  logic [AW-3:0] word;

  assign word = addr[AW-1:2];
  assign hit  = (addr[1:0] == 2'b00) && (word < (AW-2)'(NREG));
  assign idx  = hit ? word[3:0] : IX_NONE;

endmodule

// File: rtl/spi_fe_wreg.sv
module spi_fe_wreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (we)  q <= d;
  end

endmodule

// File: rtl/spi_fe_status.sv
module spi_fe_status
  import spi_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tx_empty,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic              ev_ro,
  input  logic              ev_tc,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_val,
  input  logic [STAT_W-1:0] ien_d,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq_q
);

  logic [STAT_W-1:0] stat_d;

  always_comb begin
    if (soft_rst)
      stat_d = STAT_IDLE;
    else
      stat_d = level_flags(tx_empty, tx_full, rx_empty, rx_full)
             | sticky_next(stat_q, clr_we, clr_val, ev_ro, ev_tc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_IDLE;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_level(stat_d, ien_d);
    end
  end

endmodule

// File: rtl/spi_fe_csdrv.sv
module spi_fe_csdrv #(
  parameter int NUM_CS = 4,
  parameter int CSW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              upd,
  input  logic [CSW-1:0]    sel,
  input  logic [NUM_CS-1:0] master,
  output logic [NUM_CS-1:0] cs_n
);

  logic sel_ok;
  logic sel_master;

  assign sel_ok     = ({1'b0, sel} < (CSW+1)'(NUM_CS));
  assign sel_master = sel_ok && master[sel];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cs_n[g] <= 1'b1;
      else if (soft_rst)           cs_n[g] <= 1'b1;
      else if (upd && sel_master)  cs_n[g] <= (sel != CSW'(g));
    end
  end

endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
  import spi_fe_pkg::*;
#(
  parameter int          AW         = 12,
  parameter int          NUM_CS     = 4,
  parameter int          MODE_LSB   = 4,
  parameter int          SEL_LSB    = 12,
  parameter logic [31:0] EMPTY_MARK = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [AW-1:0]     acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              acc_rvalid,
  output logic              tx_push,
  output logic [31:0]       tx_data,
  input  logic              tx_full,
  input  logic              tx_empty,
  output logic              rx_pop,
  input  logic [31:0]       rx_data,
  input  logic              rx_full,
  input  logic              rx_empty,
  output logic              fifo_flush,
  input  logic              xfer_done,
  input  logic              rx_overrun,
  output logic              irq,
  output logic [NUM_CS-1:0] cs_n,
  output logic [31:0]       ctrl_o,
  output logic [31:0]       config_o,
  output logic [31:0]       dma_o,
  output logic [31:0]       period_o
);

  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  // ---------------- decode and access events ----------------
  logic       hit;
  logic [3:0] idx;

  spi_fe_decode #(.AW(AW)) u_dec (
    .addr (acc_addr),
    .hit  (hit),
    .idx  (idx)
  );

  logic [DW-1:0] ctrl_q;
  logic          enabled;
  logic          wr_ok;
  logic          wr_ctrl;
  logic          soft_rst;
  logic          ctrl_upd;
  logic          wr_ien;
  logic          wr_stat;
  logic          wr_txd;
  logic          rd_acc;

  assign enabled  = ctrl_q[CTRL_EN];
  assign wr_ok    = acc_en && acc_wr && hit && (enabled || idx == IX_CTRL);
  assign wr_ctrl  = wr_ok && (idx == IX_CTRL);
  assign soft_rst = wr_ctrl && !acc_wdata[CTRL_EN];
  assign ctrl_upd = wr_ctrl && acc_wdata[CTRL_EN];
  assign wr_ien   = wr_ok && (idx == IX_IEN);
  assign wr_stat  = wr_ok && (idx == IX_STAT);
  assign wr_txd   = wr_ok && (idx == IX_TXD);
  assign rd_acc   = acc_en && !acc_wr;

  // FIFO strobes
  assign tx_push    = wr_txd && !tx_full;
  assign tx_data    = acc_wdata;
  assign rx_pop     = rd_acc && hit && enabled && (idx == IX_RXD) && !rx_empty;
  assign fifo_flush = soft_rst;

  // ---------------- control word ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= acc_wdata;
  end

  // ---------------- plain storage words ----------------
  logic [DW-1:0] plain_q [PLAIN_N];

  for (genvar g = 0; g < PLAIN_N; g++) begin : g_plain
    spi_fe_wreg #(.W(DW)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_rst),
      .we    (wr_ok && (idx == plain_slot(g))),
      .d     (acc_wdata),
      .q     (plain_q[g])
    );
  end

  // ---------------- interrupt enable ----------------
  logic [STAT_W-1:0] ien_q;
  logic [STAT_W-1:0] ien_d;

  always_comb begin
    if (soft_rst)    ien_d = '0;
    else if (wr_ien) ien_d = acc_wdata[STAT_W-1:0];
    else             ien_d = ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else        ien_q <= ien_d;
  end

  // ---------------- status and interrupt ----------------
  logic [STAT_W-1:0] stat_q;

  spi_fe_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .tx_empty (tx_empty),
    .tx_full  (tx_full),
    .rx_empty (rx_empty),
    .rx_full  (rx_full),
    .ev_ro    (rx_overrun),
    .ev_tc    (xfer_done),
    .clr_we   (wr_stat),
    .clr_val  (acc_wdata[STAT_W-1:0]),
    .ien_d    (ien_d),
    .stat_q   (stat_q),
    .irq_q    (irq)
  );

  // ---------------- chip selects ----------------
  spi_fe_csdrv #(.NUM_CS(NUM_CS), .CSW(CSW)) u_cs (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .upd      (ctrl_upd),
    .sel      (acc_wdata[SEL_LSB +: CSW]),
    .master   (acc_wdata[MODE_LSB +: NUM_CS]),
    .cs_n     (cs_n)
  );

  // ---------------- read path ----------------
  logic [DW-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (hit) begin
      case (idx)
        IX_RXD:  rd_word = !enabled ? '0 : (rx_empty ? EMPTY_MARK : rx_data);
        IX_CTRL: rd_word = ctrl_q;
        IX_CFG:  rd_word = plain_q[0];
        IX_IEN:  rd_word = {{(DW-STAT_W){1'b0}}, ien_q};
        IX_DMA:  rd_word = plain_q[1];
        IX_STAT: rd_word = {{(DW-STAT_W){1'b0}}, stat_q};
        IX_PER:  rd_word = plain_q[2];
        IX_TST:  rd_word = plain_q[3];
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_rdata  <= '0;
      acc_rvalid <= 1'b0;
    end else begin
      acc_rvalid <= rd_acc;
      if (rd_acc) acc_rdata <= rd_word;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign config_o = plain_q[0];
  assign dma_o    = plain_q[1];
  assign period_o = plain_q[2];

endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk
  import spi_fe_pkg::*;
#(
  parameter int AW     = 12,
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [AW-1:0]     acc_addr,
  input logic [31:0]       ctrl_o,
  input logic [31:0]       config_o,
  input logic              tx_push,
  input logic              tx_full,
  input logic              rx_pop,
  input logic              rx_empty,
  input logic              acc_rvalid,
  input logic              fifo_flush,
  input logic              xfer_done,
  input logic              irq,
  input logic [NUM_CS-1:0] cs_n,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] ien_q
);

  // R2
  disabled_cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && !ctrl_o[0] && acc_addr == AW'(12)) |=> $stable(config_o));

  // R3
  soft_reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> (cs_n == '1 && stat_q == STAT_IDLE));

  // R5
  rx_ready_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_flush |=> (stat_q[SB_RXR] == !$past(rx_empty)));

  // R6
  tc_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !fifo_flush) |=> stat_q[SB_TC]);

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(stat_q & ien_q));

  // R8
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> !tx_full);

  // R9
  no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> !rx_empty);

  // R9
  pop_gives_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> acc_rvalid);

  // R11
  cs_at_most_one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

endmodule

bind spi_fe_top spi_fe_chk #(.AW(AW), .NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_en     (acc_en),
  .acc_wr     (acc_wr),
  .acc_addr   (acc_addr),
  .ctrl_o     (ctrl_o),
  .config_o   (config_o),
  .tx_push    (tx_push),
  .tx_full    (tx_full),
  .rx_pop     (rx_pop),
  .rx_empty   (rx_empty),
  .acc_rvalid (acc_rvalid),
  .fifo_flush (fifo_flush),
  .xfer_done  (xfer_done),
  .irq        (irq),
  .cs_n       (cs_n),
  .stat_q     (stat_q),
  .ien_q      (ien_q)
);

// File: tb/sim_spi_fe_top.sv
module sim_spi_fe_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 12;
  localparam int NUM_CS     = 4;

  localparam logic [AW-1:0] A_RXD  = 12'h000;
  localparam logic [AW-1:0] A_TXD  = 12'h004;
  localparam logic [AW-1:0] A_CTRL = 12'h008;
  localparam logic [AW-1:0] A_CFG  = 12'h00C;
  localparam logic [AW-1:0] A_IEN  = 12'h010;
  localparam logic [AW-1:0] A_DMA  = 12'h014;
  localparam logic [AW-1:0] A_STAT = 12'h018;
  localparam logic [AW-1:0] A_PER  = 12'h01C;
  localparam logic [AW-1:0] A_TST  = 12'h020;
  localparam logic [AW-1:0] A_MSG  = 12'h024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_en = 1'b0;
  logic              acc_wr = 1'b0;
  logic [AW-1:0]     acc_addr = '0;
  logic [31:0]       acc_wdata = '0;
  logic [31:0]       acc_rdata;
  logic              acc_rvalid;
  logic              tx_push;
  logic [31:0]       tx_data;
  logic              tx_full = 1'b0;
  logic              tx_empty = 1'b1;
  logic              rx_pop;
  logic [31:0]       rx_data = '0;
  logic              rx_full = 1'b0;
  logic              rx_empty = 1'b1;
  logic              fifo_flush;
  logic              xfer_done = 1'b0;
  logic              rx_overrun = 1'b0;
  logic              irq;
  logic [NUM_CS-1:0] cs_n;
  logic [31:0]       ctrl_o, config_o, dma_o, period_o;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fe_top #(.AW(AW), .NUM_CS(NUM_CS)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_rvalid(acc_rvalid), .tx_push(tx_push), .tx_data(tx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_full(rx_full), .rx_empty(rx_empty), .fifo_flush(fifo_flush),
    .xfer_done(xfer_done), .rx_overrun(rx_overrun), .irq(irq), .cs_n(cs_n),
    .ctrl_o(ctrl_o), .config_o(config_o), .dma_o(dma_o), .period_o(period_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && acc_rvalid) begin
      if (exp_q.size() == 0) begin
        nchk++;
        nfail++;
        $display("FAIL R9: unexpected read data actual %h expected none", acc_rdata);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, acc_rdata, e);
      end
    end
  end

  // drivers: start and end on a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic fifo_state(input logic txe, input logic txf, input logic rxe, input logic rxf);
    tx_empty = txe; tx_full = txf; rx_empty = rxe; rx_full = rxf;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 hardware reset state
    chk("R4 irq", {31'b0, irq}, 32'h0);
    chk("R4 cs_n", {28'b0, cs_n}, 32'hF);
    chk("R4 ctrl", ctrl_o, 32'h0);
    rd(A_STAT, 32'h03, "R4 status");
    rd(A_CFG, 32'h0, "R4 config");

    // R2 disabled: writes other than control ignored
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = A_TXD; acc_wdata = 32'h1111_2222;
    #1 chk("R2 no push while disabled", {31'b0, tx_push}, 32'h0);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    wr(A_CFG, 32'h0000_0055);
    wr(A_IEN, 32'h0000_007F);
    wr(A_CTRL, 32'h0000_0001);
    rd(A_CFG, 32'h0, "R2 config kept");
    rd(A_IEN, 32'h0, "R2 irq enable kept");

    // R1 decode
    wr(A_CFG, 32'h1234_5678);
    rd(A_CFG, 32'h1234_5678, "R1 config readback");
    wr(12'h00D, 32'hFFFF_FFFF);
    rd(A_CFG, 32'h1234_5678, "R1 misaligned write ignored");
    rd(12'h00D, 32'h0, "R1 misaligned read");
    wr(12'h028, 32'hFFFF_FFFF);
    rd(12'h028, 32'h0, "R1 index 10 reads zero");
    rd(12'h400, 32'h0, "R1 high index reads zero");
    wr(A_PER, 32'h0000_00A0);
    chk("R1 period output", period_o, 32'h0000_00A0);

    // R8 transmit push and drop
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = A_TXD; acc_wdata = 32'hCAFE_0001;
    #1 chk("R8 push", {31'b0, tx_push}, 32'h1);
    chk("R8 push data", tx_data, 32'hCAFE_0001);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    tx_full = 1'b1;
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = A_TXD; acc_wdata = 32'hCAFE_0002;
    #1 chk("R8 dropped when full", {31'b0, tx_push}, 32'h0);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    tx_full = 1'b0;
    @(negedge clk);

    // R5 / R7 status mirror and interrupt timing
    wr(A_IEN, 32'h0000_0008);
    chk("R7 irq idle", {31'b0, irq}, 32'h0);
    fifo_state(1'b0, 1'b1, 1'b0, 1'b1);
    #1 chk("R7 irq not same cycle", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R7 irq next edge", {31'b0, irq}, 32'h1);
    rd(A_STAT, 32'h1C, "R5 status full pattern");
    fifo_state(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rd(A_STAT, 32'h0A, "R5 status partial pattern");
    fifo_state(1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R7 irq falls", {31'b0, irq}, 32'h0);
    rd(A_STAT, 32'h03, "R5 status idle pattern");

    // R9 receive path
    rx_data = 32'hA5A5_0001; rx_empty = 1'b0;
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = A_RXD;
    exp_q.push_back(32'hA5A5_0001); tag_q.push_back("R9 receive head");
    #1 chk("R9 pop strobe", {31'b0, rx_pop}, 32'h1);
    @(negedge clk);
    acc_en = 1'b0;
    rx_empty = 1'b1;
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = A_RXD;
    exp_q.push_back(32'hDEAD_BEEF); tag_q.push_back("R9 empty marker");
    #1 chk("R9 no pop when empty", {31'b0, rx_pop}, 32'h0);
    @(negedge clk);
    acc_en = 1'b0;
    rd(A_TXD, 32'h0, "R9 transmit reads zero");
    rd(A_MSG, 32'h0, "R9 message reads zero");

    // R10 writes to receive data and message
    rx_empty = 1'b0;
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = A_RXD; acc_wdata = 32'hFFFF_0000;
    #1 chk("R10 rx write no pop", {31'b0, rx_pop}, 32'h0);
    chk("R10 rx write no push", {31'b0, tx_push}, 32'h0);
    @(negedge clk);
    acc_addr = A_MSG; acc_en = 1'b1; acc_wr = 1'b1;
    #1 chk("R10 msg write no push", {31'b0, tx_push}, 32'h0);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    rx_empty = 1'b1;
    rd(A_MSG, 32'h0, "R10 message still zero");
    @(negedge clk);

    // R6 sticky bits
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    rd(A_STAT, 32'h43, "R6 transfer complete set");
    wr(A_STAT, 32'h0000_001F);
    rd(A_STAT, 32'h43, "R6 non-sticky write no effect");
    wr(A_STAT, 32'h0000_0040);
    rd(A_STAT, 32'h03, "R6 transfer complete cleared");
    rx_overrun = 1'b1;
    wr(A_STAT, 32'h0000_0020);
    rx_overrun = 1'b0;
    rd(A_STAT, 32'h23, "R6 event wins over clear");
    wr(A_STAT, 32'h0000_0020);
    rd(A_STAT, 32'h03, "R6 overflow cleared");

    // R11 chip select
    wr(A_CTRL, 32'h0000_2041);
    chk("R11 channel 2 selected", {28'b0, cs_n}, 32'hB);
    wr(A_CTRL, 32'h0000_1041);
    chk("R11 non-master channel holds", {28'b0, cs_n}, 32'hB);

    // R3 soft reset
    wr(A_CFG, 32'h0000_AAAA);
    wr(A_DMA, 32'h0000_0001);
    wr(A_TST, 32'h0000_0007);
    wr(A_IEN, 32'h0000_0040);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk("R3 irq before soft reset", {31'b0, irq}, 32'h1);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = A_CTRL; acc_wdata = 32'h0000_0010;
    #1 chk("R3 flush strobe", {31'b0, fifo_flush}, 32'h1);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    chk("R3 cs_n all high", {28'b0, cs_n}, 32'hF);
    chk("R3 control kept", ctrl_o, 32'h0000_0010);
    chk("R3 irq low", {31'b0, irq}, 32'h0);
    chk("R3 config cleared", config_o, 32'h0);
    chk("R3 dma cleared", dma_o, 32'h0);
    chk("R3 period cleared", period_o, 32'h0);
    rd(A_STAT, 32'h03, "R3 status idle");
    rd(A_IEN, 32'h0, "R3 irq enable cleared");
    rd(A_TST, 32'h0, "R3 test cleared");
    rd(A_RXD, 32'h0, "R9 receive read while disabled");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      nchk++;
      nfail++;
      $display("FAIL R9: actual %0d reads unanswered expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule